// File: doc/BRIEF.md
# Dual Base-and-Bound Address Relocator

This block turns logical addresses into physical ones for two access streams at once. Instruction fetches, addressed by the program counter, use a program segment register pair. Loads and stores, addressed by the memory address register, use a separate data segment register pair. In each pair, the base register holds the physical start of the segment and the limit register holds its length. For every request the block adds the base to the logical address and compares the logical address against the limit. It returns the physical address, a grant that memory may act on, and a fault flag.

The four segment registers are loaded through a small configuration port. That port only works while the supervisor-mode input is high. A write attempted from user mode leaves every register as it was and raises a one-cycle privilege-error pulse. Readback through the same port also requires supervisor mode. All registers clear to zero on reset, so until software programs them, only logical address zero is legal.

Top module: `seg_xlate_top`

## Requirements
- R1: While reset is held and just after it is released, all four segment registers read back as zero and `priv_err_o` is low.
- R2: The physical address equals the logical address plus the selected base, taken modulo 2^AW, so a sum that carries out of the top bit wraps.
- R3: A valid request is legal when its logical address is less than or equal to the selected limit. An address equal to the limit is legal.
- R4: A valid request whose logical address is greater than the limit raises the fault output and keeps the grant low. A request whose valid input is low raises neither the fault nor the grant.
- R5: The fetch channel uses the program pair only: select code 0 is the program base and code 1 is the program limit. The data channel uses the data pair only: code 2 is the data base and code 3 is the data limit. Both channels are evaluated in the same cycle without affecting each other.
- R6: A configuration write with `supervisor_i` high loads `cfg_wdata_i` into the register chosen by `cfg_sel_i` at the clock edge. The other three registers keep their values.
- R7: A configuration write with `supervisor_i` low changes no register. It drives `priv_err_o` high for exactly the one cycle after the attempt.
- R8: `cfg_rdata_o` shows the register chosen by `cfg_sel_i` while `supervisor_i` is high, and reads zero while it is low.
- R9: After reset, with all registers at zero, logical address 0 is granted at physical address 0 and any non-zero logical address faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supervisor_i | input | 1 | High while the processor runs in supervisor mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 program base, 1 program limit, 2 data base, 3 data limit |
| cfg_wdata_i | input | AW | Configuration write value |
| cfg_rdata_o | output | AW | Selected register value, or zero in user mode |
| priv_err_o | output | 1 | One-cycle pulse after a user-mode write attempt |
| if_valid_i | input | 1 | Fetch request present |
| if_laddr_i | input | AW | Fetch logical address (program counter) |
| if_paddr_o | output | AW | Fetch physical address |
| if_pvalid_o | output | 1 | Fetch granted to memory |
| if_fault_o | output | 1 | Fetch limit violation |
| dm_valid_i | input | 1 | Data request present |
| dm_laddr_i | input | AW | Data logical address (memory address register) |
| dm_paddr_o | output | AW | Data physical address |
| dm_pvalid_o | output | 1 | Data access granted to memory |
| dm_fault_o | output | 1 | Data limit violation |

## Verification
The assertions assume that `supervisor_i`, `cfg_we_i`, `cfg_sel_i` and `cfg_wdata_i` are stable around each rising edge. They also assume that the mode input is a level, not a glitch. The bench drives every input on the falling edge and holds it for at least one full cycle, so each write is seen at exactly one rising edge. Translation outputs are combinational. For that reason, the properties on address and grant are stated per cycle against the register contents at that moment. The stimulus changes registers only between translation checks.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // Register select codes: bit 1 chooses the stream, bit 0 chooses base/limit.
  typedef enum logic [1:0] {
    SEG_PROG_BASE = 2'd0,
    SEG_PROG_LIM  = 2'd1,
    SEG_DATA_BASE = 2'd2,
    SEG_DATA_LIM  = 2'd3
  } seg_reg_e;

  localparam int SEG_NUM_CH   = 2;
  localparam int SEG_NUM_REGS = 2 * SEG_NUM_CH;
  localparam int SEG_SEL_W    = $clog2(SEG_NUM_REGS);
  localparam int SEG_CH_FETCH = 0;
  localparam int SEG_CH_DATA  = 1;
endpackage

// File: rtl/seg_regbank.sv
module seg_regbank
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 supervisor_i,
  input  logic                 we_i,
  input  logic [SEG_SEL_W-1:0] sel_i,
  input  logic [AW-1:0]        wdata_i,
  output logic [AW-1:0]        rdata_o,
  output logic                 priv_err_o,
  output logic                 commit_o,
  output logic                 blocked_o,
  output logic [AW-1:0]        base_o [SEG_NUM_CH],
  output logic [AW-1:0]        lim_o  [SEG_NUM_CH]
);
  logic [AW-1:0] store_q [SEG_NUM_REGS];
  logic          priv_err_q;

  // Privilege gate: a write either commits or is blocked, never both.
  assign commit_o  = we_i &  supervisor_i;
  assign blocked_o = we_i & ~supervisor_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_NUM_REGS; i++) store_q[i] <= '0;
      priv_err_q <= 1'b0;
    end else begin
      if (commit_o) store_q[sel_i] <= wdata_i;
      priv_err_q <= blocked_o;
    end
  end

  assign priv_err_o = priv_err_q;
  assign rdata_o    = supervisor_i ? store_q[sel_i] : '0;

  // Even slots hold bases, odd slots hold limits; slot pair index is the channel.
  for (genvar ch = 0; ch < SEG_NUM_CH; ch++) begin : g_pair
    assign base_o[ch] = store_q[2*ch];
    assign lim_o[ch]  = store_q[2*ch+1];
  end
endmodule

// File: rtl/seg_channel.sv
module seg_channel #(
  parameter int AW = 32
) (
  input  logic          valid_i,
  input  logic [AW-1:0] laddr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] lim_i,
  output logic [AW-1:0] paddr_o,
  output logic          pvalid_o,
  output logic          fault_o
);
  // Sum truncated to AW bits: relocation wraps modulo 2^AW.
  function automatic logic [AW-1:0] relocate(input logic [AW-1:0] la,
                                             input logic [AW-1:0] b);
    return la + b;
  endfunction

  // Legal range is 0..limit inclusive.
  function automatic logic past_limit(input logic [AW-1:0] la,
                                      input logic [AW-1:0] lim);
    return la > lim;
  endfunction

  logic over;

  always_comb begin
    paddr_o  = relocate(laddr_i, base_i);
    over     = past_limit(laddr_i, lim_i);
    fault_o  = valid_i & over;
    pvalid_o = valid_i & ~over;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supervisor_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic [AW-1:0] cfg_rdata_o,
  output logic          priv_err_o,
  input  logic          if_valid_i,
  input  logic [AW-1:0] if_laddr_i,
  output logic [AW-1:0] if_paddr_o,
  output logic          if_pvalid_o,
  output logic          if_fault_o,
  input  logic          dm_valid_i,
  input  logic [AW-1:0] dm_laddr_i,
  output logic [AW-1:0] dm_paddr_o,
  output logic          dm_pvalid_o,
  output logic          dm_fault_o
);
  logic [AW-1:0] seg_base [SEG_NUM_CH];
  logic [AW-1:0] seg_lim  [SEG_NUM_CH];
  logic          ch_valid [SEG_NUM_CH];
  logic [AW-1:0] ch_laddr [SEG_NUM_CH];
  logic [AW-1:0] ch_paddr [SEG_NUM_CH];
  logic          ch_grant [SEG_NUM_CH];
  logic          ch_fault [SEG_NUM_CH];

  // Named internal events and register views for the checker.
  logic          cfg_commit;
  logic          cfg_blocked;
  logic [AW-1:0] prog_base, prog_lim, data_base, data_lim;

  seg_regbank #(.AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .supervisor_i(supervisor_i),
    .we_i        (cfg_we_i),
    .sel_i       (cfg_sel_i),
    .wdata_i     (cfg_wdata_i),
    .rdata_o     (cfg_rdata_o),
    .priv_err_o  (priv_err_o),
    .commit_o    (cfg_commit),
    .blocked_o   (cfg_blocked),
    .base_o      (seg_base),
    .lim_o       (seg_lim)
  );

  assign ch_valid[SEG_CH_FETCH] = if_valid_i;
  assign ch_laddr[SEG_CH_FETCH] = if_laddr_i;
  assign ch_valid[SEG_CH_DATA]  = dm_valid_i;
  assign ch_laddr[SEG_CH_DATA]  = dm_laddr_i;

  for (genvar ch = 0; ch < SEG_NUM_CH; ch++) begin : g_ch
    seg_channel #(.AW(AW)) u_ch (
      .valid_i (ch_valid[ch]),
      .laddr_i (ch_laddr[ch]),
      .base_i  (seg_base[ch]),
      .lim_i   (seg_lim[ch]),
      .paddr_o (ch_paddr[ch]),
      .pvalid_o(ch_grant[ch]),
      .fault_o (ch_fault[ch])
    );
  end

  assign if_paddr_o  = ch_paddr[SEG_CH_FETCH];
  assign if_pvalid_o = ch_grant[SEG_CH_FETCH];
  assign if_fault_o  = ch_fault[SEG_CH_FETCH];
  assign dm_paddr_o  = ch_paddr[SEG_CH_DATA];
  assign dm_pvalid_o = ch_grant[SEG_CH_DATA];
  assign dm_fault_o  = ch_fault[SEG_CH_DATA];

  assign prog_base = seg_base[SEG_CH_FETCH];
  assign prog_lim  = seg_lim[SEG_CH_FETCH];
  assign data_base = seg_base[SEG_CH_DATA];
  assign data_lim  = seg_lim[SEG_CH_DATA];
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supervisor_i,
  input logic          cfg_we_i,
  input logic [1:0]    cfg_sel_i,
  input logic [AW-1:0] cfg_wdata_i,
  input logic [AW-1:0] cfg_rdata_o,
  input logic          priv_err_o,
  input logic          cfg_blocked,
  input logic          if_valid_i,
  input logic [AW-1:0] if_laddr_i,
  input logic [AW-1:0] if_paddr_o,
  input logic          if_pvalid_o,
  input logic          if_fault_o,
  input logic          dm_valid_i,
  input logic [AW-1:0] dm_laddr_i,
  input logic [AW-1:0] dm_paddr_o,
  input logic          dm_pvalid_o,
  input logic          dm_fault_o,
  input logic [AW-1:0] prog_base,
  input logic [AW-1:0] prog_lim,
  input logic [AW-1:0] data_base,
  input logic [AW-1:0] data_lim
);
  logic [1:0]    last_sel;
  logic [AW-1:0] picked;

  always_ff @(posedge clk) last_sel <= cfg_sel_i;

  always_comb begin
    case (last_sel)
      2'd0:    picked = prog_base;
      2'd1:    picked = prog_lim;
      2'd2:    picked = data_base;
      default: picked = data_lim;
    endcase
  end

  // R4: a faulting request is never granted
  a_r4_if_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(if_fault_o && if_pvalid_o));
  a_r4_dm_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(dm_fault_o && dm_pvalid_o));
  // R4: an idle channel stays quiet
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_valid_i |-> !if_fault_o && !if_pvalid_o) and
    (!dm_valid_i |-> !dm_fault_o && !dm_pvalid_o));
  // R3: inside the limit is granted
  a_r3_if_inside: assert property (@(posedge clk) disable iff (!rst_n)
    if_valid_i && (if_laddr_i <= prog_lim) |-> if_pvalid_o);
  a_r3_dm_inside: assert property (@(posedge clk) disable iff (!rst_n)
    dm_valid_i && (dm_laddr_i <= data_lim) |-> dm_pvalid_o);
  // R2, R5: offset from the stream's own base recovers the logical address
  a_r2_if_offset: assert property (@(posedge clk) disable iff (!rst_n)
    if_pvalid_o |-> (if_paddr_o - prog_base) == if_laddr_i);
  a_r5_dm_offset: assert property (@(posedge clk) disable iff (!rst_n)
    dm_pvalid_o |-> (dm_paddr_o - data_base) == dm_laddr_i);
  // R6: a supervisor write lands in the selected register
  a_r6_commit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i && supervisor_i |=> picked == $past(cfg_wdata_i));
  // R7: a user write changes nothing and raises the error for one cycle
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i && !supervisor_i |=>
      $stable(prog_base) && $stable(prog_lim) && $stable(data_base) && $stable(data_lim));
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_blocked |=> priv_err_o);
  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we_i && !supervisor_i) |=> !priv_err_o);
  // R8: no readback outside supervisor mode
  a_r8_read_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !supervisor_i |-> cfg_rdata_o == '0);
endmodule

bind seg_xlate_top seg_xlate_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supervisor_i(supervisor_i),
  .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o), .priv_err_o(priv_err_o), .cfg_blocked(cfg_blocked),
  .if_valid_i(if_valid_i), .if_laddr_i(if_laddr_i), .if_paddr_o(if_paddr_o),
  .if_pvalid_o(if_pvalid_o), .if_fault_o(if_fault_o),
  .dm_valid_i(dm_valid_i), .dm_laddr_i(dm_laddr_i), .dm_paddr_o(dm_paddr_o),
  .dm_pvalid_o(dm_pvalid_o), .dm_fault_o(dm_fault_o),
  .prog_base(prog_base), .prog_lim(prog_lim),
  .data_base(data_base), .data_lim(data_lim)
);

// File: tb/test_seg_xlate_top.sv
module test_seg_xlate_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          supervisor_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [1:0]    cfg_sel_i = 2'd0;
  logic [AW-1:0] cfg_wdata_i = '0;
  logic [AW-1:0] cfg_rdata_o;
  logic          priv_err_o;
  logic          if_valid_i = 1'b0;
  logic [AW-1:0] if_laddr_i = '0;
  logic [AW-1:0] if_paddr_o;
  logic          if_pvalid_o, if_fault_o;
  logic          dm_valid_i = 1'b0;
  logic [AW-1:0] dm_laddr_i = '0;
  logic [AW-1:0] dm_paddr_o;
  logic          dm_pvalid_o, dm_fault_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  seg_xlate_top #(.AW(AW)) i_seg_xlate_top (.*);

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model: relocation wraps at AW bits, limit is inclusive.
  function automatic logic [AW-1:0] model_pa(input logic [AW-1:0] la, input logic [AW-1:0] b);
    logic [AW:0] s;
    s = {1'b0, la} + {1'b0, b};
    return s[AW-1:0];
  endfunction

  task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] val, input logic sup);
    @(negedge clk);
    supervisor_i = sup; cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = val;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic read_back(input string req, input logic [1:0] sel, input logic [AW-1:0] exp);
    @(negedge clk);
    supervisor_i = 1'b1; cfg_sel_i = sel;
    #1 chk(req, cfg_rdata_o, exp);
  endtask

  task automatic probe(input string req, input logic ch, input logic v, input logic [AW-1:0] la,
                       input logic [AW-1:0] b, input logic [AW-1:0] lim);
    logic ok;
    @(negedge clk);
    if (ch == 1'b0) begin if_valid_i = v; if_laddr_i = la; end
    else            begin dm_valid_i = v; dm_laddr_i = la; end
    ok = (la <= lim);
    #1;
    if (ch == 1'b0) begin
      chk(req, {31'd0, if_pvalid_o}, {31'd0, v & ok});
      chk(req, {31'd0, if_fault_o},  {31'd0, v & ~ok});
      if (v && ok) chk(req, if_paddr_o, model_pa(la, b));
    end else begin
      chk(req, {31'd0, dm_pvalid_o}, {31'd0, v & ok});
      chk(req, {31'd0, dm_fault_o},  {31'd0, v & ~ok});
      if (v && ok) chk(req, dm_paddr_o, model_pa(la, b));
    end
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) read_back("R1 reset value", 2'(s), '0);
    chk("R1 priv_err after reset", {31'd0, priv_err_o}, '0);
    probe("R9 zero address legal", 1'b0, 1'b1, '0, '0, '0);
    probe("R9 nonzero address faults", 1'b0, 1'b1, 32'h5, '0, '0);
    probe("R9 data nonzero faults", 1'b1, 1'b1, 32'h1, '0, '0);
  endtask

  task automatic t_program();
    cfg_write(2'd0, 32'h0000_1000, 1'b1);
    cfg_write(2'd1, 32'h0000_00FF, 1'b1);
    cfg_write(2'd2, 32'h8000_0000, 1'b1);
    cfg_write(2'd3, 32'h0000_0010, 1'b1);
    read_back("R6 prog base", 2'd0, 32'h0000_1000);
    read_back("R6 prog limit", 2'd1, 32'h0000_00FF);
    read_back("R6 data base", 2'd2, 32'h8000_0000);
    read_back("R6 data limit", 2'd3, 32'h0000_0010);
  endtask

  task automatic t_translate();
    probe("R2 fetch relocation", 1'b0, 1'b1, 32'h20, 32'h1000, 32'hFF);
    probe("R3 data at limit legal", 1'b1, 1'b1, 32'h10, 32'h8000_0000, 32'h10);
    probe("R4 data one past limit", 1'b1, 1'b1, 32'h11, 32'h8000_0000, 32'h10);
    probe("R4 fetch past limit", 1'b0, 1'b1, 32'h100, 32'h1000, 32'hFF);
  endtask

  task automatic t_streams();
    // R5: same logical address on both channels in one cycle, different pairs
    @(negedge clk);
    if_valid_i = 1'b1; if_laddr_i = 32'h8;
    dm_valid_i = 1'b1; dm_laddr_i = 32'h8;
    #1;
    chk("R5 fetch uses program base", if_paddr_o, 32'h0000_1008);
    chk("R5 data uses data base", dm_paddr_o, 32'h8000_0008);
    chk("R5 both granted", {30'd0, if_pvalid_o, dm_pvalid_o}, 32'h3);
    @(negedge clk);
    if_laddr_i = 32'h50; dm_laddr_i = 32'h50;
    #1;
    chk("R5 fetch limit is program limit", {31'd0, if_pvalid_o}, 32'h1);
    chk("R5 data limit is data limit", {31'd0, dm_fault_o}, 32'h1);
  endtask

  task automatic t_idle();
    probe("R4 idle fetch quiet", 1'b0, 1'b0, 32'hFFFF_0000, 32'h1000, 32'hFF);
    probe("R4 idle data quiet", 1'b1, 1'b0, 32'hFFFF_0000, 32'h8000_0000, 32'h10);
  endtask

  task automatic t_wrap();
    cfg_write(2'd2, 32'hFFFF_FFF0, 1'b1);
    cfg_write(2'd3, 32'hFFFF_FFFF, 1'b1);
    probe("R2 wrap modulo 2^AW", 1'b1, 1'b1, 32'h20, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
    probe("R3 max address at max limit", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 32'hFFFF_FFFF);
  endtask

  task automatic t_user_write();
    @(negedge clk);
    supervisor_i = 1'b0; cfg_we_i = 1'b1; cfg_sel_i = 2'd0; cfg_wdata_i = 32'hDEAD_0000;
    #1 chk("R8 user read is zero", cfg_rdata_o, '0);
    @(negedge clk);
    cfg_we_i = 1'b0;
    #1 chk("R7 priv_err raised", {31'd0, priv_err_o}, 32'h1);
    @(negedge clk);
    #1 chk("R7 priv_err one cycle", {31'd0, priv_err_o}, '0);
    read_back("R7 prog base unchanged", 2'd0, 32'h0000_1000);
    read_back("R7 other registers unchanged", 2'd1, 32'h0000_00FF);
    probe("R7 fetch still uses old base", 1'b0, 1'b1, 32'h4, 32'h1000, 32'hFF);
    @(negedge clk);
    supervisor_i = 1'b1; cfg_sel_i = 2'd2;
    #1 chk("R8 supervisor read shows register", cfg_rdata_o, 32'hFFFF_FFF0);
    supervisor_i = 1'b0;
    #1 chk("R8 user read hides register", cfg_rdata_o, '0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    supervisor_i = 1'b1; cfg_sel_i = 2'd0;
    #1 chk("R1 readback during reset", cfg_rdata_o, '0);
    rst_n = 1'b1;
    t_reset();
    t_program();
    t_translate();
    t_streams();
    t_idle();
    t_wrap();
    t_user_write();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule